// File: doc/BRIEF.md
# Interrupt-Driven Peripheral Transfer Engine

This block answers an interrupt request by moving a single byte or word between two locations of the lowest 64 KB address segment, instead of letting the CPU enter a handler. It holds a small set of channels. Each channel has a 16-bit source pointer, a 16-bit destination pointer, an 8-bit transfer count and a 4-bit control word. An interrupt line assigned to an enabled channel with a nonzero count asks the CPU to stall. In the cycle the CPU grants the bus, the engine reads the source and writes the destination in that same cycle. It may then advance one of the two pointers and decrement the count. One cycle later it pulses an acknowledge back to the requesting source.

A request whose channel is disabled, or whose count has run down to zero, is forwarded unchanged to the CPU as an ordinary interrupt. Software sets up channels through a write-only configuration port. The memory side is a one-cycle port with separate read and write addresses. Read data returns in the same cycle, and byte enables select the written lane.

Top module: `irq_xfer_engine`

## Requirements
- R1: After reset all channels are disabled with zero pointers and count, so `stall_req`, `mem_en` and `irq_ack` are low and every live request appears on `cpu_irq`.
- R2: A configuration write updates channel `cfg_ch` at the next clock edge: `cfg_sel` 0 writes the source pointer, 1 the destination pointer, 2 the count (low 8 bits), 3 the control word (low 4 bits). If a write and a transfer update the same field in the same cycle, the write wins.
- R3: Control bit 0 enables the channel and bit 1 selects word size (1) over byte size (0). A request on a disabled channel is forwarded to `cpu_irq` and starts no transfer.
- R4: `stall_req` is high exactly while some channel is eligible (live request, enabled, nonzero count). A transfer (`mem_en`) happens only in a cycle where `stall_req` and `stall_gnt` are both high, and it occupies that single cycle.
- R5: A byte transfer reads at the full source address and takes the upper data lane when address bit 0 is 1, the lower lane otherwise. It drives that byte on both lanes of `mem_wdata`, with `mem_be` = 2'b10 for an odd destination and 2'b01 for an even one.
- R6: A word transfer forces bit 0 of both addresses to 0, copies all 16 read bits unchanged and drives `mem_be` = 2'b11.
- R7: Control bits [3:2] pick the pointer advanced after a transfer: 01 the source, 10 the destination, 00 or 11 neither. The step is 1 for bytes and 2 for words, and the pointer wraps modulo 2^16.
- R8: Each transfer decrements the count unless the count is 8'hFF, which means unlimited. A channel with count 0 is not eligible, and its requests go to `cpu_irq`.
- R9: When several channels are eligible in a granted cycle, the lowest-numbered one is served and the rest wait.
- R10: In the cycle after a transfer, `irq_ack` carries a one-cycle pulse on the served channel only. During that cycle the channel's request is neither served nor forwarded, so the source must drop it by the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CHW | Channel written |
| cfg_sel | input | 2 | Field written: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | 16 | Configuration data |
| irq_req | input | NCH | Interrupt requests assigned to the channels |
| irq_ack | output | NCH | Transfer-done pulse per channel |
| cpu_irq | output | NCH | Requests forwarded to the CPU as normal interrupts |
| stall_req | output | 1 | Asks the CPU to give up the bus |
| stall_gnt | input | 1 | CPU gives up the bus this cycle |
| mem_en | output | 1 | Transfer cycle on the memory port |
| mem_raddr | output | 16 | Read address |
| mem_rdata | input | 16 | Read data, same cycle |
| mem_waddr | output | 16 | Write address |
| mem_wdata | output | 16 | Write data |
| mem_be | output | 2 | Write byte enables |

## Verification
The hardest situation to reach is a channel being reconfigured in the very cycle it transfers. That cycle needs a live request, a granted stall and a write to the same channel all at once, and it must also not fall in the source's acknowledge window. The bench creates it once on purpose and then leaves it to thousands of random cycles, where writes, requests and grants are drawn independently. Counts are mostly drawn small, so channels keep running dry and handing requests to the CPU. A reference model in the bench checks every cycle.

// File: rtl/irq_xfer_engine.sv
module irq_xfer_engine #(
  parameter int NCH  = 4,
  parameter int CNTW = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_we,
  input  logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] cfg_ch,
  input  logic [1:0]                           cfg_sel,
  input  logic [15:0]                          cfg_wdata,
  input  logic [NCH-1:0]                       irq_req,
  output logic [NCH-1:0]                       irq_ack,
  output logic [NCH-1:0]                       cpu_irq,
  output logic                                 stall_req,
  input  logic                                 stall_gnt,
  output logic                                 mem_en,
  output logic [15:0]                          mem_raddr,
  input  logic [15:0]                          mem_rdata,
  output logic [15:0]                          mem_waddr,
  output logic [15:0]                          mem_wdata,
  output logic [1:0]                           mem_be
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [CNTW-1:0] CNT_FOREVER = '1;

  logic [15:0]     src_q [NCH];
  logic [15:0]     dst_q [NCH];
  logic [CNTW-1:0] cnt_q [NCH];
  logic [3:0]      ctl_q [NCH];
  logic [NCH-1:0]  ack_q, live, elig;
  logic [CHW-1:0]  sel;
  logic            go, word, inc_src, inc_dst;
  logic [15:0]     cur_src, cur_dst, step;
  logic [7:0]      rbyte;

  assign live = irq_req & ~ack_q;

  always_comb begin
    for (int i = 0; i < NCH; i++)
      elig[i] = live[i] && ctl_q[i][0] && (cnt_q[i] != '0);
  end

  always_comb begin
    sel = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (elig[i]) sel = CHW'(i);
  end

  assign cpu_irq   = live & ~elig;
  assign stall_req = |elig;
  assign go        = stall_req & stall_gnt;
  assign irq_ack   = ack_q;

  assign cur_src = src_q[sel];
  assign cur_dst = dst_q[sel];
  assign word    = ctl_q[sel][1];
  assign inc_src = ctl_q[sel][3:2] == 2'b01;
  assign inc_dst = ctl_q[sel][3:2] == 2'b10;
  assign step    = word ? 16'd2 : 16'd1;

  assign mem_en    = go;
  assign mem_raddr = word ? {cur_src[15:1], 1'b0} : cur_src;
  assign mem_waddr = word ? {cur_dst[15:1], 1'b0} : cur_dst;
  assign rbyte     = cur_src[0] ? mem_rdata[15:8] : mem_rdata[7:0];
  assign mem_wdata = word ? mem_rdata : {rbyte, rbyte};
  assign mem_be    = word ? 2'b11 : (cur_dst[0] ? 2'b10 : 2'b01);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
        cnt_q[i] <= '0;
        ctl_q[i] <= '0;
      end
    end else begin
      ack_q <= go ? (NCH'(1) << sel) : '0;
      for (int i = 0; i < NCH; i++) begin
        if (go && sel == CHW'(i)) begin
          if (inc_src) src_q[i] <= src_q[i] + step;
          if (inc_dst) dst_q[i] <= dst_q[i] + step;
          if (cnt_q[i] != CNT_FOREVER) cnt_q[i] <= cnt_q[i] - 1'b1;
        end
        if (cfg_we && cfg_ch == CHW'(i)) begin
          case (cfg_sel)
            2'd0: src_q[i] <= cfg_wdata;
            2'd1: dst_q[i] <= cfg_wdata;
            2'd2: cnt_q[i] <= cfg_wdata[CNTW-1:0];
            default: ctl_q[i] <= cfg_wdata[3:0];
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/irq_xfer_engine_chk.sv
module irq_xfer_engine_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] irq_ack,
  input logic [NCH-1:0] cpu_irq,
  input logic           stall_req,
  input logic           stall_gnt,
  input logic           mem_en,
  input logic [15:0]    mem_raddr,
  input logic [15:0]    mem_waddr,
  input logic [15:0]    mem_wdata,
  input logic [1:0]     mem_be
);
  AST_GRANTED_ONLY: assert property (@(posedge clk) disable iff (!rst_n) mem_en |-> stall_req && stall_gnt); // R4
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n) !stall_req |-> !mem_en); // R4
  AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n) mem_en && mem_be == 2'b11 |-> !mem_raddr[0] && !mem_waddr[0]); // R6
  AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n) mem_en && mem_be != 2'b11 |-> mem_be == (mem_waddr[0] ? 2'b10 : 2'b01)); // R5
  AST_BYTE_COPY: assert property (@(posedge clk) disable iff (!rst_n) mem_en && mem_be != 2'b11 |-> mem_wdata[15:8] == mem_wdata[7:0]); // R5
  AST_ACK_AFTER: assert property (@(posedge clk) disable iff (!rst_n) mem_en |=> $countones(irq_ack) == 1); // R10
  AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !mem_en |=> irq_ack == '0); // R10
  AST_NO_FWD_ACK: assert property (@(posedge clk) disable iff (!rst_n) (cpu_irq & irq_ack) == '0); // R10
endmodule

bind irq_xfer_engine irq_xfer_engine_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .cpu_irq(cpu_irq),
  .stall_req(stall_req), .stall_gnt(stall_gnt), .mem_en(mem_en),
  .mem_raddr(mem_raddr), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_be(mem_be)
);

// File: tb/irq_xfer_engine_tb.sv
module irq_xfer_engine_tb;
  localparam int NCH = 4;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_ch = 0, cfg_sel = 0;
  logic [15:0] cfg_wdata = 0;
  logic [NCH-1:0] irq_req = 0, irq_ack, cpu_irq;
  logic stall_req, stall_gnt = 0, mem_en;
  logic [15:0] mem_raddr, mem_rdata, mem_waddr, mem_wdata;
  logic [1:0] mem_be;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [15:0] m_src [NCH];
  logic [15:0] m_dst [NCH];
  logic [7:0]  m_cnt [NCH];
  logic [3:0]  m_ctl [NCH];
  logic [NCH-1:0] m_ack = 0;

  always #10 clk = ~clk;

  function automatic logic [15:0] rd_fn(logic [15:0] a);
    return {a[7:0] + 8'h3C, a[15:8] ^ a[7:0] ^ 8'h96};
  endfunction
  assign mem_rdata = rd_fn(mem_raddr);

  irq_xfer_engine #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .irq_req(irq_req), .irq_ack(irq_ack), .cpu_irq(cpu_irq),
    .stall_req(stall_req), .stall_gnt(stall_gnt), .mem_en(mem_en), .mem_raddr(mem_raddr),
    .mem_rdata(mem_rdata), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_be(mem_be));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle(bit we, logic [1:0] ch, logic [1:0] fsel, logic [15:0] wd,
                       logic [NCH-1:0] req, bit gnt, string atag);
    logic [NCH-1:0] live, elig;
    logic [1:0] s;
    bit go, wrd;
    logic [15:0] ra, wa, rd, step;
    logic [7:0] b;
    @(negedge clk);
    cfg_we = we; cfg_ch = ch; cfg_sel = fsel; cfg_wdata = wd;
    irq_req = req; stall_gnt = gnt;
    #2;
    live = req & ~m_ack;
    for (int i = 0; i < NCH; i++) elig[i] = live[i] & m_ctl[i][0] & (m_cnt[i] != 0);
    s = 0;
    for (int i = NCH - 1; i >= 0; i--) if (elig[i]) s = 2'(i);
    go = (|elig) && gnt;
    for (int i = 0; i < NCH; i++)
      chk(m_ctl[i][0] ? "R8 forward" : "R3 forward", 32'(cpu_irq[i]), 32'(live[i] & ~elig[i]));
    chk("R4 stall", 32'(stall_req), 32'(|elig));
    chk("R4 mem_en", 32'(mem_en), 32'(go));
    chk("R10 ack", 32'(irq_ack), 32'(m_ack));
    if (go) begin
      wrd = m_ctl[s][1];
      ra = wrd ? {m_src[s][15:1], 1'b0} : m_src[s];
      wa = wrd ? {m_dst[s][15:1], 1'b0} : m_dst[s];
      rd = rd_fn(ra);
      b = m_src[s][0] ? rd[15:8] : rd[7:0];
      chk($countones(elig) > 1 ? "R9 raddr" : atag, 32'(mem_raddr), 32'(ra));
      chk(atag, 32'(mem_waddr), 32'(wa));
      chk(wrd ? "R6 wdata" : "R5 wdata", 32'(mem_wdata), 32'(wrd ? rd : {b, b}));
      chk(wrd ? "R6 be" : "R5 be", 32'(mem_be), wrd ? 32'd3 : (m_dst[s][0] ? 32'd2 : 32'd1));
    end
    @(posedge clk); #1;
    if (go) begin
      step = m_ctl[s][1] ? 16'd2 : 16'd1;
      if (m_ctl[s][3:2] == 2'b01) m_src[s] = m_src[s] + step;
      if (m_ctl[s][3:2] == 2'b10) m_dst[s] = m_dst[s] + step;
      if (m_cnt[s] != 8'hFF) m_cnt[s] = m_cnt[s] - 1;
    end
    if (we) case (fsel)
      2'd0: m_src[ch] = wd;
      2'd1: m_dst[ch] = wd;
      2'd2: m_cnt[ch] = wd[7:0];
      default: m_ctl[ch] = wd[3:0];
    endcase
    m_ack = go ? (NCH'(1) << s) : '0;
  endtask

  task automatic cfg(logic [1:0] ch, logic [1:0] fsel, logic [15:0] wd);
    cycle(1, ch, fsel, wd, '0, 0, "R2 addr");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #3000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [NCH-1:0] rq;
    int unused_seed;
    unused_seed = $urandom(32'h5EED1234);
    for (int i = 0; i < NCH; i++) begin
      m_src[i] = 0; m_dst[i] = 0; m_cnt[i] = 0; m_ctl[i] = 0;
    end
    irq_req = 4'b1010;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 cpu_irq", 32'(cpu_irq), 32'hA);
    chk("R1 stall", 32'(stall_req), 0);
    chk("R1 mem_en", 32'(mem_en), 0);
    chk("R1 ack", 32'(irq_ack), 0);
    @(negedge clk); rst_n = 1;
    cycle(0, 0, 0, 0, 4'b1111, 1, "R1 addr");

    cfg(0, 0, 16'h0101); cfg(0, 1, 16'h2000); cfg(0, 2, 16'd3); cfg(0, 3, 16'b0101);
    cfg(1, 0, 16'h3001); cfg(1, 1, 16'h4003); cfg(1, 2, 16'hFF); cfg(1, 3, 16'b1011);
    cfg(2, 0, 16'h50FF); cfg(2, 1, 16'hFFFF); cfg(2, 2, 16'd1); cfg(2, 3, 16'b1001);
    cfg(3, 2, 16'd5);    cfg(3, 3, 16'b1100);

    cycle(0, 0, 0, 0, 4'b1110, 0, "R9 addr");
    cycle(0, 0, 0, 0, 4'b1110, 1, "R9 addr");
    cycle(0, 0, 0, 0, 4'b1100, 1, "R10 addr");
    cycle(0, 0, 0, 0, 4'b1000, 0, "R8 addr");
    cycle(0, 0, 0, 0, 4'b0100, 1, "R8 addr");
    cycle(0, 0, 0, 0, 4'b0001, 1, "R7 addr");
    cycle(0, 0, 0, 0, 4'b0000, 0, "R7 addr");
    cycle(0, 0, 0, 0, 4'b0001, 1, "R7 addr");
    cycle(1, 0, 0, 16'h4444, 4'b0000, 0, "R2 addr");
    cycle(1, 0, 0, 16'h7777, 4'b0001, 1, "R2 addr");
    cycle(0, 0, 0, 0, 4'b0000, 0, "R2 addr");
    cycle(1, 0, 2, 16'd2, 4'b0000, 0, "R2 addr");
    cycle(0, 0, 0, 0, 4'b0001, 1, "R2 addr");
    cycle(0, 0, 0, 0, 4'b0010, 1, "R6 addr");

    rq = 0;
    for (int k = 0; k < 4000; k++) begin
      bit we;
      logic [1:0] ch, fs;
      logic [15:0] wd;
      for (int i = 0; i < NCH; i++) begin
        if (m_ack[i]) rq[i] = 0;
        else if (rq[i]) begin if ($urandom_range(9) == 0) rq[i] = 0; end
        else if ($urandom_range(3) == 0) rq[i] = 1;
      end
      we = ($urandom_range(7) == 0);
      ch = 2'($urandom_range(3));
      fs = 2'($urandom_range(3));
      wd = 16'($urandom);
      if (fs == 2'd2) case ($urandom_range(4))
        0: wd = 16'h00FF;
        1: wd = 16'd0;
        default: wd = 16'($urandom_range(1, 4));
      endcase
      if (fs == 2'd3 && $urandom_range(3) != 0) wd[0] = 1'b1;
      cycle(we, ch, fs, wd, rq, $urandom_range(9) < 7, "R7 addr");
    end
    finish_run();
  end
endmodule